// File: doc/BRIEF.md
# Complementary Ultrasonic Burst Generator

This block produces periodic ultrasonic ping bursts on two push-pull outputs that drive a pair of piezo transducers wired in parallel. While a burst runs, the two outputs are always in antiphase, so the transducers see twice the logic swing peak to peak. Every half-period of the tone is 12.5 us, which gives a 40 kHz tone. One burst is exactly eight full tone cycles, and a free-running repetition timer starts a new burst about every 25 ms.

Between bursts both outputs sit low, so the transducers never hold a static differential voltage. Every burst ends on a whole tone cycle. A one-cycle strobe marks the first drive edge of each burst. A second one-cycle strobe marks the cycle on which the outputs go back to idle. Receive-side logic uses these strobes to open its blanking and listening windows. The clock frequency, tone frequency, pulse count and repetition rate are all parameters, and every interval is an integer count of clock cycles.

Top module: `sonar_ping_gen`

## Requirements
- R1: While reset is high, and on the first cycle after it, both drive outputs and both strobes are low.
- R2: While a burst is running, `tx_pos` and `tx_neg` always have opposite values.
- R3: Each half-period of the drive waveform lasts exactly HALF_CYC = CLK_HZ/(2*TONE_HZ) clock cycles. `tx_pos` is high in the even-numbered halves (0, 2, 4, ...) and low in the odd-numbered ones.
- R4: Each burst contains exactly PULSES rising edges of `tx_pos`.
- R5: The first burst starts REP_CYC = CLK_HZ/REP_HZ clock edges after reset is released. Each later burst starts exactly REP_CYC cycles after the one before it.
- R6: Outside a burst, both outputs are low.
- R7: `burst_start` is high for exactly one cycle, and that is the cycle on which `tx_pos` first rises.
- R8: `burst_done` is high for one cycle, 2*PULSES*HALF_CYC cycles after `burst_start`. On that same cycle both outputs return low. On the cycle before it, the last half of the final pulse is complete, with `tx_pos` low and `tx_neg` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| tx_pos | output | 1 | Push-pull drive, in-phase leg |
| tx_neg | output | 1 | Push-pull drive, antiphase leg |
| burst_start | output | 1 | One-cycle strobe on the first drive edge of a burst |
| burst_done | output | 1 | One-cycle strobe when the outputs return to idle |

## Verification
A half-cycle counter off by one shows up at the first tone transition, 12.5 us into a burst. A wrong half index shows up as an extra or missing pulse when the burst ends, together with a shifted `burst_done`. A repetition counter that is wrong only appears at the next burst start, one full interval away. For that reason the bench compares every cycle against a model indexed by cycles since reset, and it applies resets at random points, including in the middle of a burst.

// File: rtl/sonar_ping_pkg.sv
package sonar_ping_pkg;

    // Counter width that stays legal for a limit of one.
    function automatic int cnt_width(input int limit);
        return (limit <= 1) ? 1 : $clog2(limit);
    endfunction

    // Integer number of clock cycles in one period of a rate.
    function automatic int cycles_per(input int clk_hz, input int rate_hz);
        return clk_hz / rate_hz;
    endfunction

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_DRIVE = 1'b1
    } seq_state_e;

    // State that the sequencer hands to the output stage.
    typedef struct packed {
        seq_state_e state;      // idle or driving
        logic       odd_half;   // current half index is odd
    } tone_phase_t;

    // The drive pair on the output pins.
    typedef struct packed {
        logic pos;
        logic neg;
    } drive_pair_t;

    localparam drive_pair_t DRIVE_IDLE = '{pos: 1'b0, neg: 1'b0};

endpackage

// File: rtl/sonar_rep_timer.sv
module sonar_rep_timer #(
    parameter int REP_CYC = 20000
) (
    input  logic clk,
    input  logic rst,
    output logic fire
);
    localparam int RW = sonar_ping_pkg::cnt_width(REP_CYC);
    localparam logic [RW-1:0] LAST = RW'(REP_CYC - 1);

    logic [RW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign fire = !rst && (cnt == LAST);

    AST_REP_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST); // R5
    AST_REP_WRAP: assert property (@(posedge clk) disable iff (rst)
        fire |=> (cnt == '0)); // R5

endmodule

// File: rtl/sonar_tone_seq.sv
module sonar_tone_seq
    import sonar_ping_pkg::*;
#(
    parameter int HALF_CYC   = 10,
    parameter int NUM_HALVES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fire,
    output tone_phase_t phase,
    output logic        started,
    output logic        finished
);
    localparam int HW = cnt_width(HALF_CYC);
    localparam int IW = cnt_width(NUM_HALVES);
    localparam logic [HW-1:0] HALF_LAST = HW'(HALF_CYC - 1);
    localparam logic [IW-1:0] IDX_LAST  = IW'(NUM_HALVES - 1);

    seq_state_e    state;
    logic [HW-1:0] hcnt;
    logic [IW-1:0] hidx;
    logic          half_end;
    logic          last_half;

    assign half_end  = (state == SEQ_DRIVE) && (hcnt == HALF_LAST);
    assign last_half = (hidx == IDX_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_IDLE;
            hcnt     <= '0;
            hidx     <= '0;
            started  <= 1'b0;
            finished <= 1'b0;
        end else begin
            started  <= 1'b0;
            finished <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (fire) begin
                        state   <= SEQ_DRIVE;
                        hcnt    <= '0;
                        hidx    <= '0;
                        started <= 1'b1;
                    end
                end
                SEQ_DRIVE: begin
                    if (half_end) begin
                        hcnt <= '0;
                        if (last_half) begin
                            state    <= SEQ_IDLE;
                            hidx     <= '0;
                            finished <= 1'b1;
                        end else begin
                            hidx <= hidx + 1'b1;
                        end
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign phase.state    = state;
    assign phase.odd_half = hidx[0];

    AST_HALF_RANGE: assert property (@(posedge clk) disable iff (rst)
        hcnt <= HALF_LAST); // R3
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        hidx <= IDX_LAST); // R4
    AST_END_ON_ODD: assert property (@(posedge clk) disable iff (rst)
        (half_end && last_half) |-> hidx[0]); // R8

endmodule

// File: rtl/sonar_drive_stage.sv
module sonar_drive_stage
    import sonar_ping_pkg::*;
(
    input  tone_phase_t phase,
    output drive_pair_t drive
);
    always_comb begin
        drive = DRIVE_IDLE;
        if (phase.state == SEQ_DRIVE) begin
            drive.pos = !phase.odd_half;
            drive.neg = phase.odd_half;
        end
    end
endmodule

// File: rtl/sonar_ping_gen.sv
module sonar_ping_gen
    import sonar_ping_pkg::*;
#(
    parameter int CLK_HZ  = 125_000_000,
    parameter int TONE_HZ = 40_000,
    parameter int PULSES  = 8,
    parameter int REP_HZ  = 40
) (
    input  logic clk,
    input  logic rst,
    output logic tx_pos,
    output logic tx_neg,
    output logic burst_start,
    output logic burst_done
);
    localparam int HALF_CYC   = cycles_per(CLK_HZ, 2 * TONE_HZ);
    localparam int NUM_HALVES = 2 * PULSES;
    localparam int REP_CYC    = cycles_per(CLK_HZ, REP_HZ);

    logic        fire;
    tone_phase_t phase;
    drive_pair_t drive;

    sonar_rep_timer #(.REP_CYC(REP_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .fire (fire)
    );

    sonar_tone_seq #(.HALF_CYC(HALF_CYC), .NUM_HALVES(NUM_HALVES)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .phase    (phase),
        .started  (burst_start),
        .finished (burst_done)
    );

    sonar_drive_stage u_drive (
        .phase (phase),
        .drive (drive)
    );

    assign tx_pos = drive.pos;
    assign tx_neg = drive.neg;

    AST_TX_OPPOSITE: assert property (@(posedge clk) disable iff (rst)
        (phase.state == SEQ_DRIVE) |-> (tx_pos != tx_neg)); // R2
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        (phase.state == SEQ_IDLE) |-> (!tx_pos && !tx_neg)); // R6
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        fire |-> (phase.state == SEQ_IDLE)); // R5
    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        burst_start |=> !burst_start); // R7
    AST_START_EDGE: assert property (@(posedge clk) disable iff (rst)
        burst_start |-> (tx_pos && !$past(tx_pos))); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        burst_done |=> !burst_done); // R8
    AST_DONE_FULL: assert property (@(posedge clk) disable iff (rst)
        burst_done |-> (!tx_pos && !tx_neg && $past(tx_neg) && !$past(tx_pos))); // R8

endmodule

// File: tb/tb_sonar_ping_gen.sv
module tb_sonar_ping_gen;
    localparam int CLK_HZ  = 800_000;
    localparam int TONE_HZ = 40_000;
    localparam int PULSES  = 8;
    localparam int REP_HZ  = 40;
    localparam int HALF    = CLK_HZ / (2 * TONE_HZ);   // 10
    localparam int REP     = CLK_HZ / REP_HZ;          // 20000
    localparam int BURST   = 2 * PULSES * HALF;        // 160

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_pos, tx_neg, burst_start, burst_done;

    int checks = 0;
    int errors = 0;
    longint n = 0;        // edges since reset release
    int rises = 0;
    logic prev_pos = 1'b0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    sonar_ping_gen #(.CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ), .PULSES(PULSES),
                     .REP_HZ(REP_HZ)) dut (
        .clk(clk), .rst(rst), .tx_pos(tx_pos), .tx_neg(tx_neg),
        .burst_start(burst_start), .burst_done(burst_done));

    // Expected {pos, neg, start, done} after n edges out of reset.
    function automatic logic [3:0] model(input longint k);
        longint off;
        longint half;
        if (k < REP) return 4'b0000;
        off = (k - REP) % REP;
        if (off < BURST) begin
            half = off / HALF;
            return {(half % 2 == 0), (half % 2 == 1), (off == 0), 1'b0};
        end
        return {2'b00, 1'b0, (off == BURST)};
    endfunction

    task automatic check(input bit ok, input string req, input longint act,
                         input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at n=%0d: actual %0d expected %0d", req, n, act, exp);
        end
    endtask

    task automatic step();
        logic [3:0] e;
        @(posedge clk);
        if (rst) n = 0; else n = n + 1;
        @(negedge clk);
        e = model(n);
        if (rst) begin
            check({tx_pos, tx_neg, burst_start, burst_done} == 4'b0, "R1",
                  {tx_pos, tx_neg, burst_start, burst_done}, 0);
            rises = 0;
        end else begin
            if (e[3] != e[2])
                check(tx_pos != tx_neg, "R2", {tx_pos, tx_neg}, {e[3], e[2]});
            check(tx_pos == e[3], (e[3] | e[2]) ? "R3" : "R6", tx_pos, e[3]);
            check(tx_neg == e[2], (e[3] | e[2]) ? "R3" : "R6", tx_neg, e[2]);
            check(burst_start == e[1], "R7", burst_start, e[1]);
            check(burst_done == e[0], "R8", burst_done, e[0]);
            if (burst_start)
                check(n >= REP && n % REP == 0, "R5", n % REP, 0);
            if (tx_pos && !prev_pos) rises++;
            if (burst_done) begin
                check(rises == PULSES, "R4", rises, PULSES);
                check(!prev_pos, "R8", prev_pos, 0);
                rises = 0;
            end
        end
        prev_pos = tx_pos;
    endtask

    initial begin
        #(64'd200_000 * 8);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1;
        repeat (5) step();
        @(negedge clk) rst = 1'b0;
        // R1: first cycle after release still idle
        step();
        check({tx_pos, tx_neg, burst_start, burst_done} == 4'b0, "R1",
              {tx_pos, tx_neg, burst_start, burst_done}, 0);
        // Two full intervals: first-burst timing (R5) and repeat
        for (int i = 0; i < 2 * REP + BURST + 10; i++) step();
        // Random resets, some landing inside a burst
        for (int t = 0; t < 3; t++) begin
            int wait_c;
            int hold;
            wait_c = int'($urandom_range(REP + BURST, REP - 40));
            if (t == 0) wait_c = REP - int'(n % REP) + 50; // mid-burst directed
            hold = int'($urandom_range(4, 1));
            for (int i = 0; i < wait_c; i++) step();
            @(negedge clk) rst = 1'b1;
            for (int i = 0; i < hold; i++) step();
            @(negedge clk) rst = 1'b0;
            for (int i = 0; i < REP + BURST + 5; i++) step();
        end
        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule